// File: doc/BRIEF.md
# Wait-Request Clock Stretcher

This block stalls a processor without relying on the processor's own ready pin. When a wait is needed, the block holds the processor's phase clock high. It watches a slow system clock and an active-low wait request. Normally it passes the system clock through as the phase clock. If it sees a wait request while the system clock is high, it pins the phase clock high. The phase clock stays pinned until the request is withdrawn during a later high interval of the system clock. Because the processor is frozen in its high phase, anything latched on the processor's clock edges also stays put for the whole wait.

The block runs on a fast sampling clock. Both the system clock and the wait request pass through synchronizers of equal depth, so their relative timing is kept. A registered set/reset state then models the classic two-NAND latch, and a registered OR gate produces the phase clock. There is no data stream, so every pin is a plain level.

Top module: `clk_stretch_ctl`

## Requirements
- R1: While no hold is active, `phase_clk` equals `sys_clk` delayed by `SYNC_STAGES`+1 sampling-clock cycles.
- R2: The hold is set when the synchronized `sys_clk` is 1 and the synchronized `wait_n` is 0 in the same sampling cycle.
- R3: While the hold is set, `phase_clk` is 1 whatever `sys_clk` does.
- R4: The hold is cleared only when the synchronized `sys_clk` and `wait_n` are both 1. While the synchronized `sys_clk` is 0, the hold state never changes. After clearing, `phase_clk` follows `sys_clk` again.
- R5: If `wait_n` is 0 only while `sys_clk` is 0, `phase_clk` stays 0. The hold begins only at the next high interval of `sys_clk` during which `wait_n` is still 0.
- R6: While `rst_n` is 0, `phase_clk` is 0 and the hold is clear, so `phase_clk` follows `sys_clk` right after reset.
- R7: `phase_clk` never shows a runt low pulse. It falls only in the cycle that follows a fall of the delayed `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clk | input | 1 | Slow system clock, sampled as data |
| wait_n | input | 1 | Wait request, 0 asks for a stall |
| phase_clk | output | 1 | Processor phase clock, stretched high during a hold |

## Verification
The bench uses the default `SYNC_STAGES` of 2 and a system clock of eight sampling cycles. This gives a small, fully repeatable timing grid. On that grid it sweeps the cycle where the wait request starts over all eight phases of the system clock. It also sweeps the length of the wait request from zero to twelve cycles, and adds one long stall. Together these cover:
- requests confined to the low phase;
- requests that straddle an edge;
- releases during a high phase and during a low phase.

Every sample is compared against a model built from the requirements, and every fall of the phase clock is checked against a fall of the delayed system clock.

// File: rtl/clk_stretch_pkg.sv
package clk_stretch_pkg;
  localparam int SYNC_STAGES_DEF = 2;
  typedef enum logic {HOLD_OFF = 1'b0, HOLD_ON = 1'b1} hold_e;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hold_latch.sv
module hold_latch
  import clk_stretch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_q,
  input  logic rdy_q,
  output logic hold
);
  hold_e st;
  logic  set_c, clr_c;

  assign set_c = clk_q & ~rdy_q;
  assign clr_c = clk_q & rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st <= HOLD_OFF;
    else if (set_c) st <= HOLD_ON;
    else if (clr_c) st <= HOLD_OFF;
  end

  assign hold = (st == HOLD_ON);

  assert_hold_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && !rdy_q) |=> hold);
  assert_hold_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && rdy_q) |=> !hold);
  assert_hold_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_q |=> $stable(hold));
endmodule

// File: rtl/phase_gate.sv
module phase_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_q,
  input  logic hold,
  output logic phase_clk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_clk <= 1'b0;
    else        phase_clk <= clk_q | hold;
  end

  assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (phase_clk == $past(clk_q)));
  assert_held_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> phase_clk);
  assert_no_runt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_clk) |-> ($past(clk_q, 2) && !$past(clk_q)));
endmodule

// File: rtl/clk_stretch_ctl.sv
module clk_stretch_ctl
  import clk_stretch_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic samp_clk,
  input  logic rst_n,
  input  logic sys_clk,
  input  logic wait_n,
  output logic phase_clk
);
  logic clk_q, rdy_q, hold;

  lvl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
    .clk(samp_clk), .rst_n(rst_n), .d(sys_clk), .q(clk_q));

  lvl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(samp_clk), .rst_n(rst_n), .d(wait_n), .q(rdy_q));

  hold_latch u_hold (
    .clk(samp_clk), .rst_n(rst_n), .clk_q(clk_q), .rdy_q(rdy_q), .hold(hold));

  phase_gate u_gate (
    .clk(samp_clk), .rst_n(rst_n), .clk_q(clk_q), .hold(hold),
    .phase_clk(phase_clk));
endmodule

// File: tb/test_clk_stretch_ctl.sv
module test_clk_stretch_ctl;
  localparam int S   = 2;
  localparam int D   = S + 3;
  localparam int PER = 8;

  logic samp_clk = 1'b0;
  logic rst_n    = 1'b0;
  logic sys_clk  = 1'b0;
  logic wait_n   = 1'b1;
  logic phase_clk;

  int checks = 0;
  int errors = 0;
  int ph     = 0;
  bit done   = 1'b0;

  logic hc [D];
  logic hr [D];
  logic hh [D];
  logic prev_out = 1'b0;

  always #2 samp_clk = ~samp_clk;

  clk_stretch_ctl #(.SYNC_STAGES(S)) i_clk_stretch_ctl (
    .samp_clk(samp_clk), .rst_n(rst_n), .sys_clk(sys_clk),
    .wait_n(wait_n), .phase_clk(phase_clk));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at ph %0d: actual %b expected %b", tag, ph, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (hh[S+1] && !hh[S+2]) return "R2";
    if (hh[S+1])             return "R3";
    if (hh[S+2])             return "R4";
    if (!hc[S] && !hr[S])    return "R5";
    return "R1";
  endfunction

  // One sampling cycle: drive, consume edge, update model, check at negedge.
  task automatic step(input logic r);
    logic c;
    logic exp;
    c = ((ph % PER) < (PER / 2));
    sys_clk = c;
    wait_n  = r;
    @(posedge samp_clk);
    for (int k = D - 1; k > 0; k--) begin
      hc[k] = hc[k-1]; hr[k] = hr[k-1]; hh[k] = hh[k-1];
    end
    hc[0] = c;
    hr[0] = r;
    if (c && !r)     hh[0] = 1'b1;
    else if (c && r) hh[0] = 1'b0;
    else             hh[0] = hh[1];
    @(negedge samp_clk);
    exp = hc[S] | hh[S+1];
    check(tag_of(), phase_clk, exp);
    if (prev_out && !phase_clk)
      check("R7", hc[S+1] & ~hc[S], 1'b1);
    prev_out = phase_clk;
    ph++;
  endtask

  initial begin
    for (int k = 0; k < D; k++) begin
      hc[k] = 1'b0; hr[k] = 1'b1; hh[k] = 1'b0;
    end
    // R6: reset state, with sys_clk toggling
    for (int k = 0; k < 6; k++) begin
      @(negedge samp_clk);
      sys_clk = k[0];
      check("R6", phase_clk, 1'b0);
    end
    sys_clk = 1'b0;
    @(negedge samp_clk);
    rst_n = 1'b1;
    // R6: follows sys_clk right after reset
    for (int k = 0; k < 3 * PER; k++) step(1'b1);
    // sweep wait start phase and length
    for (int off = 0; off < PER; off++) begin
      for (int len = 0; len <= 12; len++) begin
        while ((ph % PER) != off) step(1'b1);
        for (int k = 0; k < len; k++) step(1'b0);
        for (int k = 0; k < 2 * PER; k++) step(1'b1);
      end
    end
    // long stall, then release in a low phase
    while ((ph % PER) != 2) step(1'b1);
    for (int k = 0; k < 45; k++) step(1'b0);
    for (int k = 0; k < 3 * PER; k++) step(1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule